// File: doc/BRIEF.md
# Serial Channel Register Controller

This block is the register-level front end of one serial channel. A byte-wide host bus reads and writes a small set of registers. The block keeps the channel's status byte, decodes a command byte that switches the receiver and transmitter on and off and resets parts of the channel, and stores received characters in a three-entry holding queue. It drives three interrupt-request flags toward a block-level interrupt collector: transmitter ready, receiver has data, and break seen.

Received characters and break events come in on a valid/ready port. A break is stored as a zero character. Its status bit only turns into a break interrupt once a character is popped while that bit is set. Bytes written to the transmit holding register leave on a one-cycle valid/data port, and only while the transmitter is enabled.

The register select decodes as follows: 0 mode pair, 1 status (a write here is clock-select and is ignored), 2 command, 3 holding (a read pops receive, a write sends transmit), 4 auxiliary control (ignored), 5 output port (ignored). Selects 6 and 7 read as zero. The host asserts at most one of read or write per cycle, and read data is valid combinationally while the read is driven.

Top module: `serial_chan_ctrl`

## Requirements
- R1: After reset the receiver and transmitter are disabled, the mode pointer selects the first mode entry, the queue is empty, the status reads 0x00, and rx_ready and all three interrupt flags are low.
- R2: In a command write, bit 0 enables receive and bit 1 disables it. When both are set, receive ends up disabled. rx_ready is high only while receive is enabled.
- R3: Command bit 2 enables transmit: status bits 2 (transmitter ready) and 3 (transmitter empty) and irq_txrdy all go high. Bit 3 disables transmit and clears all three, and it wins over bit 2. Command code 3 in bits 7:4 also clears all three.
- R4: A write to the holding select produces tx_valid high for exactly the following cycle, with tx_data equal to the written byte, only if transmit is enabled. Otherwise the byte is discarded.
- R5: The mode pair shares select 0. Each read or write uses the entry chosen by the pointer, and afterwards the pointer selects the second entry. Command code 1 in bits 7:4 points it back to the first entry.
- R6: The queue holds three bytes and returns them in arrival order. rx_ready is high only when receive is enabled and fewer than three bytes are held. Offers made while rx_ready is low are dropped. Status bit 1 is high while three bytes are held.
- R7: A holding read returns the entry at the read index. When the queue is empty the read changes nothing. The read that empties the queue clears status bit 0 and irq_rxrdy.
- R8: An accepted byte is written at (read index + count) mod 3. Status bit 0 and irq_rxrdy are set whenever the queue holds data.
- R9: Command code 2 in bits 7:4 disables receive, empties the queue and clears status bit 0 and irq_rxrdy.
- R10: An accepted break event (rx_valid with rx_brk) stores a zero character. If status bit 7 is clear, it also sets status bit 7 and irq_brk. Status bits 4 to 6 always read zero.
- R11: A holding read that pops a byte while status bit 7 is set clears bit 7 and sets irq_brk. Command code 4 clears status bits 4 to 7. Command code 5 clears irq_brk.
- R12: When a host access and a receive event fall in the same cycle, the host access takes effect first, and the accepted character is then stored into the resulting state.
- R13: Writes to selects 1, 4, 5, 6 and 7, and command codes 6 to 15 in bits 7:4, change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | AW (3) | Register select |
| bus_wdata | input | DW (8) | Host write data |
| bus_rdata | output | DW (8) | Read data for the current select |
| rx_valid | input | 1 | Receive event offered |
| rx_brk | input | 1 | Offered event is a break |
| rx_data | input | DW (8) | Received character |
| rx_ready | output | 1 | Receive event will be accepted |
| tx_valid | output | 1 | Transmit byte valid (one cycle) |
| tx_data | output | DW (8) | Transmit byte |
| irq_txrdy | output | 1 | Transmitter-ready interrupt flag |
| irq_rxrdy | output | 1 | Receiver-has-data interrupt flag |
| irq_brk | output | 1 | Break interrupt flag |

## Verification
The collision that matters is a holding-register pop arriving in the same cycle as an incoming character or break. Pops that drain the last byte, and pops that convert a pending break status into an interrupt, are the interesting cases. The bench provokes this directly, for example by popping the only held byte while a break arrives. It then keeps provoking it through random cycles in which host reads and receive offers overlap freely. Each result is judged against a bench model that applies the host access first and the receive event second, and compares read data, rx_ready and all interrupt flags every cycle.

// File: rtl/serial_chan_pkg.sv
`timescale 1ns/1ps
package serial_chan_pkg;

  typedef enum logic [2:0] {
    RS_MODE  = 3'd0,
    RS_STAT  = 3'd1,
    RS_CMD   = 3'd2,
    RS_HOLD  = 3'd3,
    RS_AUX   = 3'd4,
    RS_OPORT = 3'd5
  } reg_sel_e;

  typedef struct packed {
    logic rx_on;
    logic rx_off;
    logic tx_on;
    logic tx_off;
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic err_clr;
    logic brk_clr;
  } chan_cmd_t;

  function automatic int unsigned ring_next(int unsigned idx, int unsigned depth);
    return (idx + 1 >= depth) ? 0 : idx + 1;
  endfunction

  function automatic int unsigned ring_pos(int unsigned base, int unsigned ofs,
                                           int unsigned depth);
    return (base + ofs) % depth;
  endfunction

endpackage

// File: rtl/chan_cmd_decode.sv
`timescale 1ns/1ps
module chan_cmd_decode
  import serial_chan_pkg::*;
(
  input  logic       en,
  input  logic [7:0] code,
  output chan_cmd_t  cmd
);
  always_comb begin
    cmd = '0;
    if (en) begin
      cmd.rx_on  = code[0];
      cmd.rx_off = code[1];
      cmd.tx_on  = code[2];
      cmd.tx_off = code[3];
      unique case (code[7:4])
        4'd1:    cmd.ptr_rst = 1'b1;
        4'd2:    cmd.rx_rst  = 1'b1;
        4'd3:    cmd.tx_rst  = 1'b1;
        4'd4:    cmd.err_clr = 1'b1;
        4'd5:    cmd.brk_clr = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mode_pair.sv
`timescale 1ns/1ps
module mode_pair #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          access,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          ptr_rst,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] entry_q [2];
  logic          ptr_q;

  assign rdata = entry_q[ptr_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry_q[0] <= '0;
      entry_q[1] <= '0;
      ptr_q      <= 1'b0;
    end else begin
      if (access && wr) entry_q[ptr_q] <= wdata;
      if (access)       ptr_q <= 1'b1;
      else if (ptr_rst) ptr_q <= 1'b0;
    end
  end

  p_ptr_after_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
    access |=> ptr_q);
  p_ptr_rewind_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_rst && !access) |=> !ptr_q);
endmodule

// File: rtl/rx_hold_fifo.sv
`timescale 1ns/1ps
module rx_hold_fifo
  import serial_chan_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 3,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count,
  output logic          pop_ok,
  output logic          drained
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [IW-1:0] rd_idx_q, idx_mid, wr_pos;
  logic [CW-1:0] cnt_mid, count_n;

  assign rd_data = mem_q[rd_idx_q];

  always_comb begin
    pop_ok  = pop && (count != '0);
    drained = pop_ok && (count == CW'(1));
    cnt_mid = flush ? '0 : (pop_ok ? count - CW'(1) : count);
    idx_mid = (pop_ok && !drained) ? IW'(ring_next(32'(rd_idx_q), DEPTH)) : rd_idx_q;
    wr_pos  = IW'(ring_pos(32'(idx_mid), 32'(cnt_mid), DEPTH));
    count_n = push ? cnt_mid + CW'(1) : cnt_mid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      rd_idx_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      count    <= count_n;
      rd_idx_q <= idx_mid;
      if (push) mem_q[wr_pos] <= push_data;
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_push_has_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_mid < CW'(DEPTH)));
  p_empty_pop_inert_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && count == '0 && !push && !flush) |=> (count == '0 && $stable(rd_idx_q)));
endmodule

// File: rtl/serial_chan_ctrl.sv
`timescale 1ns/1ps
module serial_chan_ctrl
  import serial_chan_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 3,
  parameter int AW    = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rx_valid,
  input  logic          rx_brk,
  input  logic [DW-1:0] rx_data,
  output logic          rx_ready,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  output logic          irq_txrdy,
  output logic          irq_rxrdy,
  output logic          irq_brk
);
  localparam logic [AW-1:0] A_MODE = AW'(RS_MODE);
  localparam logic [AW-1:0] A_STAT = AW'(RS_STAT);
  localparam logic [AW-1:0] A_CMD  = AW'(RS_CMD);
  localparam logic [AW-1:0] A_HOLD = AW'(RS_HOLD);

  // host strobes (write has priority if both are driven)
  logic host_rd, mode_acc, pop_req, cmd_wr, tx_wr;
  assign host_rd  = bus_rd && !bus_wr;
  assign mode_acc = (host_rd || bus_wr) && (bus_addr == A_MODE);
  assign pop_req  = host_rd && (bus_addr == A_HOLD);
  assign cmd_wr   = bus_wr && (bus_addr == A_CMD);
  assign tx_wr    = bus_wr && (bus_addr == A_HOLD);

  chan_cmd_t cmd;
  chan_cmd_decode u_dec (.en(cmd_wr), .code(bus_wdata[7:0]), .cmd(cmd));

  logic [DW-1:0] mode_rdata;
  mode_pair #(.DW(DW)) u_mode (
    .clk(clk), .rst_n(rst_n), .access(mode_acc), .wr(bus_wr),
    .wdata(bus_wdata), .ptr_rst(cmd.ptr_rst), .rdata(mode_rdata));

  logic          rx_en_q, tx_on_q, rxrdy_q, brk_sr_q, irq_brk_q;
  logic          rx_push, pop_ok, drained;
  logic [DW-1:0] fifo_rd;
  logic [CW-1:0] fifo_cnt;

  assign rx_ready = rx_en_q && (fifo_cnt < CW'(DEPTH));
  assign rx_push  = rx_valid && rx_ready;

  rx_hold_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .pop(pop_req), .flush(cmd.rx_rst),
    .push(rx_push), .push_data(rx_brk ? '0 : rx_data),
    .rd_data(fifo_rd), .count(fifo_cnt), .pop_ok(pop_ok), .drained(drained));

  // host step first, then receive step
  logic brk_mid, irqb_mid;
  always_comb begin
    brk_mid  = (pop_ok || cmd.err_clr) ? 1'b0 : brk_sr_q;
    irqb_mid = cmd.brk_clr ? 1'b0 : ((pop_ok && brk_sr_q) ? 1'b1 : irq_brk_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en_q   <= 1'b0;
      tx_on_q   <= 1'b0;
      rxrdy_q   <= 1'b0;
      brk_sr_q  <= 1'b0;
      irq_brk_q <= 1'b0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
    end else begin
      if (cmd.rx_off || cmd.rx_rst) rx_en_q <= 1'b0;
      else if (cmd.rx_on)           rx_en_q <= 1'b1;
      if (cmd.tx_off || cmd.tx_rst) tx_on_q <= 1'b0;
      else if (cmd.tx_on)           tx_on_q <= 1'b1;
      if (rx_push)                    rxrdy_q <= 1'b1;
      else if (cmd.rx_rst || drained) rxrdy_q <= 1'b0;
      if (rx_push && rx_brk && !brk_mid) begin
        brk_sr_q  <= 1'b1;
        irq_brk_q <= 1'b1;
      end else begin
        brk_sr_q  <= brk_mid;
        irq_brk_q <= irqb_mid;
      end
      tx_valid <= tx_wr && tx_on_q;
      if (tx_wr && tx_on_q) tx_data <= bus_wdata;
    end
  end

  logic [7:0] status;
  assign status = {brk_sr_q, 3'b000, tx_on_q, tx_on_q,
                   (fifo_cnt == CW'(DEPTH)), rxrdy_q};

  always_comb begin
    unique case (bus_addr)
      A_MODE:  bus_rdata = mode_rdata;
      A_STAT:  bus_rdata = DW'(status);
      A_HOLD:  bus_rdata = fifo_rd;
      default: bus_rdata = '0;
    endcase
  end

  assign irq_txrdy = tx_on_q;
  assign irq_rxrdy = rxrdy_q;
  assign irq_brk   = irq_brk_q;

  p_rdy_tracks_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rxrdy_q == (fifo_cnt != '0));
  p_full_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_cnt == CW'(DEPTH)) |-> !rx_ready);
  p_tx_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_on_q);
  p_brk_pop_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && brk_sr_q) |=> irq_brk_q);
  p_break_sets_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_brk) |=> brk_sr_q);
  p_rx_reset_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.rx_rst && !rx_push) |=> (fifo_cnt == '0 && !rx_en_q));
endmodule

// File: tb/tb_serial_chan_ctrl.sv
`timescale 1ns/1ps
module tb_serial_chan_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rd = 0, bus_wr = 0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       rx_valid = 0, rx_brk = 0;
  logic [7:0] rx_data = '0;
  logic       rx_ready, tx_valid, irq_txrdy, irq_rxrdy, irq_brk;
  logic [7:0] tx_data;

  always #2.5 clk = ~clk;

  serial_chan_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_brk(rx_brk), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq_txrdy(irq_txrdy),
    .irq_rxrdy(irq_rxrdy), .irq_brk(irq_brk));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  bit       m_rxen, m_tx, m_ptr, m_rxrdy, m_brk, m_irqb, m_txv;
  bit [7:0] m_mr [2];
  bit [7:0] m_q [3];
  int       m_idx, m_cnt;
  bit [7:0] m_txd;

  task automatic model_reset();
    m_rxen = 0; m_tx = 0; m_ptr = 0; m_rxrdy = 0; m_brk = 0; m_irqb = 0;
    m_txv = 0; m_txd = 0; m_mr[0] = 0; m_mr[1] = 0; m_idx = 0; m_cnt = 0;
    for (int i = 0; i < 3; i++) m_q[i] = 0;
  endtask

  function automatic bit [7:0] model_read(bit [2:0] a);
    case (a)
      3'd0: return m_mr[m_ptr];
      3'd1: return {m_brk, 3'b000, m_tx, m_tx, (m_cnt == 3), m_rxrdy};
      3'd3: return m_q[m_idx];
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_step(bit rd, bit wr, bit [2:0] a, bit [7:0] d,
                            bit rv, bit rb, bit [7:0] rdat);
    bit acc;
    acc   = rv && m_rxen && (m_cnt < 3);
    m_txv = wr && a == 3'd3 && m_tx;
    if (m_txv) m_txd = d;
    if (wr) begin
      if (a == 3'd0) begin m_mr[m_ptr] = d; m_ptr = 1; end
      else if (a == 3'd2) begin
        if (d[0]) m_rxen = 1;
        if (d[1]) m_rxen = 0;
        if (d[2]) m_tx = 1;
        if (d[3]) m_tx = 0;
        case (d[7:4])
          4'd1: m_ptr = 0;
          4'd2: begin m_rxen = 0; m_cnt = 0; m_rxrdy = 0; end
          4'd3: m_tx = 0;
          4'd4: m_brk = 0;
          4'd5: m_irqb = 0;
          default: ;
        endcase
      end
    end else if (rd) begin
      if (a == 3'd0) m_ptr = 1;
      else if (a == 3'd3 && m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) m_rxrdy = 0; else m_idx = (m_idx + 1) % 3;
        if (m_brk) begin m_brk = 0; m_irqb = 1; end
      end
    end
    if (acc) begin
      if (rb && !m_brk) begin m_brk = 1; m_irqb = 1; end
      m_q[(m_idx + m_cnt) % 3] = rb ? 8'h00 : rdat;
      m_cnt++;
      m_rxrdy = 1;
    end
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit rd, bit wr, bit [2:0] a, bit [7:0] d,
                     bit rv, bit rb, bit [7:0] rdat, string tag);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
    rx_valid = rv; rx_brk = rb; rx_data = rdat;
    #1;
    chk(rx_ready == (m_rxen && m_cnt < 3), "R6", "rx_ready", rx_ready, m_rxen && m_cnt < 3);
    chk(irq_txrdy == m_tx, "R3", "irq_txrdy", irq_txrdy, m_tx);
    chk(irq_rxrdy == m_rxrdy, "R8", "irq_rxrdy", irq_rxrdy, m_rxrdy);
    chk(irq_brk == m_irqb, "R11", "irq_brk", irq_brk, m_irqb);
    chk(tx_valid == m_txv, "R4", "tx_valid", tx_valid, m_txv);
    if (m_txv) chk(tx_data == m_txd, "R4", "tx_data", tx_data, m_txd);
    if (rd && !wr) chk(bus_rdata == model_read(a), tag, "rdata", bus_rdata, model_read(a));
    model_step(rd, wr, a, d, rv, rb, rdat);
    @(posedge clk);
  endtask

  task automatic wr(bit [2:0] a, bit [7:0] d, string tag); cyc(0, 1, a, d, 0, 0, 0, tag); endtask
  task automatic rd(bit [2:0] a, string tag);              cyc(1, 0, a, 0, 0, 0, 0, tag); endtask
  task automatic rx(bit [7:0] d, bit b, string tag);       cyc(0, 0, 0, 0, 1, b, d, tag); endtask
  task automatic idle();                                   cyc(0, 0, 0, 0, 0, 0, 0, "idle"); endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit [7:0] codes [12] = '{8'h01, 8'h02, 8'h04, 8'h08, 8'h05, 8'h10,
                             8'h20, 8'h30, 8'h40, 8'h50, 8'h0F, 8'hA0};
    void'($urandom(32'h5EED1));
    model_reset();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(3'd1, "R1"); rd(3'd0, "R1");
    // R5 mode pair pointer
    wr(3'd0, 8'h11, "R5"); wr(3'd0, 8'h22, "R5"); rd(3'd0, "R5");
    wr(3'd2, 8'h10, "R5"); rd(3'd0, "R5"); rd(3'd0, "R5");
    // R2 enable/disable receive in one write
    wr(3'd2, 8'h03, "R2"); rx(8'hAA, 0, "R2"); rd(3'd1, "R2");
    wr(3'd2, 8'h01, "R2"); idle();
    // R3 transmit enable and disable
    wr(3'd2, 8'h04, "R3"); rd(3'd1, "R3");
    wr(3'd2, 8'h0C, "R3"); rd(3'd1, "R3");
    wr(3'd2, 8'h04, "R3"); wr(3'd2, 8'h30, "R3"); rd(3'd1, "R3");
    // R4 send only while enabled
    wr(3'd3, 8'h77, "R4"); idle();
    wr(3'd2, 8'h04, "R4"); wr(3'd3, 8'h5A, "R4"); idle(); idle();
    // R6 fill, overflow drop, drain in order; R7 empty pop
    rx(8'hA1, 0, "R6"); rx(8'hA2, 0, "R6"); rx(8'hA3, 0, "R6");
    rx(8'hA4, 0, "R6"); rd(3'd1, "R6");
    rd(3'd3, "R6"); rd(3'd3, "R6"); rd(3'd3, "R7");
    rd(3'd1, "R7"); rd(3'd3, "R7"); rd(3'd1, "R7");
    // R10 break, repeated break; R11 pop converts, clear commands
    rx(8'hFF, 1, "R10"); rd(3'd1, "R10"); rx(8'hEE, 1, "R10");
    rd(3'd3, "R11"); rd(3'd1, "R11");
    wr(3'd2, 8'h50, "R11"); rx(8'h00, 1, "R11"); wr(3'd2, 8'h40, "R11");
    rd(3'd1, "R11"); wr(3'd2, 8'h50, "R11");
    rd(3'd3, "R11"); rd(3'd3, "R11");
    // R12 pop of last byte together with a break arrival
    rx(8'h3C, 0, "R12");
    cyc(1, 0, 3'd3, 0, 1, 1, 8'h99, "R12");
    rd(3'd1, "R12"); rd(3'd3, "R12"); rd(3'd1, "R12");
    // R9 receiver reset with data held
    wr(3'd2, 8'h01, "R9"); rx(8'h12, 0, "R9"); rx(8'h34, 0, "R9");
    wr(3'd2, 8'h20, "R9"); rd(3'd1, "R9"); rx(8'h56, 0, "R9"); rd(3'd1, "R9");
    // R13 ignored writes
    wr(3'd2, 8'h01, "R13"); rx(8'h9C, 0, "R13"); rd(3'd1, "R13");
    wr(3'd1, 8'hFF, "R13"); wr(3'd4, 8'hFF, "R13"); wr(3'd5, 8'hFF, "R13");
    wr(3'd6, 8'hFF, "R13"); wr(3'd7, 8'hFF, "R13");
    wr(3'd2, 8'h60, "R13"); wr(3'd2, 8'hF0, "R13");
    rd(3'd1, "R13"); rd(3'd0, "R13"); rd(3'd3, "R13");
    rd(3'd6, "R13");
    // R12 random mix of overlapping host and receive traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      bit rv, rb;
      bit [7:0] d;
      r  = $urandom % 100;
      rv = ($urandom % 2) == 0;
      rb = ($urandom % 10) == 0;
      d  = 8'($urandom);
      if      (r < 25) cyc(1, 0, 3'd3, 0, rv, rb, d, "R12");
      else if (r < 35) cyc(1, 0, 3'd1, 0, rv, rb, d, "R12");
      else if (r < 45) cyc(0, 1, 3'd3, 8'($urandom), rv, rb, d, "R12");
      else if (r < 60) cyc(0, 1, 3'd2, codes[$urandom % 12], rv, rb, d, "R12");
      else if (r < 63) cyc(1, 0, 3'd0, 0, rv, rb, d, "R12");
      else if (r < 66) cyc(0, 1, 3'd0, 8'($urandom), rv, rb, d, "R12");
      else if (r < 70) cyc(0, 1, 3'($urandom % 2 ? 4 : 5), 8'($urandom), rv, rb, d, "R12");
      else             cyc(0, 0, 3'd0, 0, rv, rb, d, "R12");
    end
    idle();
    finish_run();
  end
endmodule